// File: doc/BRIEF.md
# NAND Strobe Timing Calculator

This block turns a set of NAND interface timing figures, each given in picoseconds, into the seven cycle counts that an asynchronous memory controller needs for one chip select. Read setup, read strobe, read hold and bus turnaround cover the read side. Write setup, write strobe and write hold cover the write side. The bus clock period is given in whole nanoseconds. A one-cycle `start` pulse captures every input. The block then steps through a short sequence of conversions and reports the results with `done`.

Every conversion shares one rounding-up divider. First the picosecond figure is divided down to whole nanoseconds, truncating toward zero. The result is then divided by the period and rounded up. Each field is that cycle count less one, floored at zero. After the per-field values are set, the strobe and hold fields are raised one count per clock until a few combined-cycle minimums hold. Those minimums carry fixed offsets. All arithmetic is signed 32-bit, so a negative difference ends in a zero field. The block does not check the results against the widths of any controller register.

Top module: `nand_strobe_calc`

## Requirements
- R1: Define cyc(x) = (trunc(x / 1000) + P - 1) / P, where P is the period in ns, both divisions are signed and truncate toward zero, and all values are 32-bit signed. Every field starts as max(cyc(...) - 1, 0) of its source. Every field reported with `done` is non-negative.
- R2: Read setup equals max(cyc(CLE-to-RE delay) - 1, 0).
- R3: Read strobe starts as max(max(cyc(RE access + 3000), cyc(RE pulse)) - 1, 0). It is then raised by one per clock until read setup + read strobe >= cyc(CE access + 3000) - 2.
- R4: Read hold starts as max(cyc(1600 - CE-high-to-Z) - 1, 0). It is then raised by one per clock until the three read fields sum to at least cyc(read cycle) - 3.
- R5: Turnaround equals max(max(cyc(RE-high-to-Z - (read hold + 1) * P * 1000), cyc(CE-high-to-Z)) - 1, 0). The read hold used here is the final value, after it has been raised.
- R6: Write setup equals max(max of cyc of the CLE, ALE and CE setup times, minus 1, 0). Write strobe starts as max(cyc(WE pulse) - 1, 0). It is then raised until write setup + write strobe >= cyc(data setup) - 2.
- R7: Write hold starts as max(max of cyc of the CLE, ALE, CE and data hold times, minus 1, 0). It is then raised until the three write fields sum to at least cyc(write cycle) - 2.
- R8: After reset, `done` is 0 and every field is 0. A `start` pulse while idle or finished makes `done` low on the next cycle. `done` goes high when all constraints hold. `done` and every field then stay unchanged until the next `start`.
- R9: The inputs are sampled only on an accepted `start`. A `start` pulse or an input change while a calculation is running has no effect on that run's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin a calculation |
| period_ns | input | 32 | Clock period in ns, signed, greater than zero |
| clr_dly_ps | input | 32 | CLE-to-RE delay, ps |
| re_access_ps | input | 32 | RE access time, ps |
| re_pulse_ps | input | 32 | RE pulse width, ps |
| ce_access_ps | input | 32 | CE access time, ps |
| ce_hiz_ps | input | 32 | CE high to output high-Z, ps |
| rd_cycle_ps | input | 32 | Read cycle time, ps |
| re_hiz_ps | input | 32 | RE high to output high-Z, ps |
| we_pulse_ps | input | 32 | WE pulse width, ps |
| cle_setup_ps | input | 32 | CLE setup, ps |
| ale_setup_ps | input | 32 | ALE setup, ps |
| ce_setup_ps | input | 32 | CE setup, ps |
| dat_setup_ps | input | 32 | Data setup, ps |
| cle_hold_ps | input | 32 | CLE hold, ps |
| ale_hold_ps | input | 32 | ALE hold, ps |
| ce_hold_ps | input | 32 | CE hold, ps |
| dat_hold_ps | input | 32 | Data hold, ps |
| wr_cycle_ps | input | 32 | Write cycle time, ps |
| rd_setup | output | 32 | Read setup cycles |
| rd_strobe | output | 32 | Read strobe cycles |
| rd_hold | output | 32 | Read hold cycles |
| turnaround | output | 32 | Bus turnaround cycles |
| wr_setup | output | 32 | Write setup cycles |
| wr_strobe | output | 32 | Write strobe cycles |
| wr_hold | output | 32 | Write hold cycles |
| done | output | 1 | Results valid |

## Verification
Wrong step ordering or operand selection gives a wrong field value once `done` rises. A grow loop that stops early or late shows up as a strobe or hold that is off by the missing or extra counts. A stale read hold used in the turnaround operand shows as a wrong turnaround, but only for profiles where the grow loop actually changed the hold. A sequencer that fails to ignore a mid-run `start` shows as results that match the second input set instead of the first. Every such error becomes visible at the ports within one run, tens to a few hundred cycles after `start`.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

  localparam int TW = 32;

  typedef logic signed [TW-1:0] s32_t;

  typedef struct packed {
    s32_t clr_dly;
    s32_t re_access;
    s32_t re_pulse;
    s32_t ce_access;
    s32_t ce_hiz;
    s32_t rd_cycle;
    s32_t re_hiz;
    s32_t we_pulse;
    s32_t cle_setup;
    s32_t ale_setup;
    s32_t ce_setup;
    s32_t dat_setup;
    s32_t cle_hold;
    s32_t ale_hold;
    s32_t ce_hold;
    s32_t dat_hold;
    s32_t wr_cycle;
  } timing_t;

  // One state per conversion or grow loop, in the order the fields depend on each other
  typedef enum logic [4:0] {
    ST_IDLE, ST_CLR, ST_REA, ST_RP, ST_CEA, ST_GRS,
    ST_CHZH, ST_RC, ST_GRH, ST_RHZ, ST_CHZ, ST_WP,
    ST_CLS, ST_ALS, ST_CS, ST_DS, ST_GWS,
    ST_CLH, ST_ALH, ST_CH, ST_DH, ST_WC, ST_GWH, ST_DONE
  } step_e;

  // Picoseconds to cycles: truncate to ns, then round up by the period
  function automatic s32_t ps_to_cyc(s32_t ps, s32_t per);
    s32_t ns;
    ns = ps / 32'sd1000;
    return (ns + per - 32'sd1) / per;
  endfunction

  function automatic s32_t floor0(s32_t v);
    return (v < 0) ? '0 : v;
  endfunction

  function automatic s32_t smax(s32_t a, s32_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nsc_opsel.sv
module nsc_opsel
  import nsc_pkg::*;
#(
  parameter int IN_SETUP_PS = 3000,
  parameter int IN_HOLD_PS  = 1600
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    capture,
  input  timing_t t_in,
  input  s32_t    per_in,
  input  step_e   step,
  input  s32_t    hold_now,
  output s32_t    operand,
  output s32_t    per_q
);

  localparam s32_t SETUP_K = s32_t'(IN_SETUP_PS);
  localparam s32_t HOLD_K  = s32_t'(IN_HOLD_PS);

  timing_t t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      per_q <= 32'sd1;
    end else if (capture) begin
      t_q   <= t_in;
      per_q <= per_in;
    end
  end

  always_comb begin
    unique case (step)
      ST_CLR:  operand = t_q.clr_dly;
      ST_REA:  operand = t_q.re_access + SETUP_K;
      ST_RP:   operand = t_q.re_pulse;
      ST_CEA:  operand = t_q.ce_access + SETUP_K;
      ST_CHZH: operand = HOLD_K - t_q.ce_hiz;
      ST_RC:   operand = t_q.rd_cycle;
      ST_RHZ:  operand = t_q.re_hiz - (hold_now + 32'sd1) * per_q * 32'sd1000;
      ST_CHZ:  operand = t_q.ce_hiz;
      ST_WP:   operand = t_q.we_pulse;
      ST_CLS:  operand = t_q.cle_setup;
      ST_ALS:  operand = t_q.ale_setup;
      ST_CS:   operand = t_q.ce_setup;
      ST_DS:   operand = t_q.dat_setup;
      ST_CLH:  operand = t_q.cle_hold;
      ST_ALH:  operand = t_q.ale_hold;
      ST_CH:   operand = t_q.ce_hold;
      ST_DH:   operand = t_q.dat_hold;
      ST_WC:   operand = t_q.wr_cycle;
      default: operand = '0;
    endcase
  end

endmodule

// File: rtl/nsc_cycconv.sv
module nsc_cycconv
  import nsc_pkg::*;
(
  input  s32_t operand,
  input  s32_t per,
  output s32_t cycles
);

  assign cycles = ps_to_cyc(operand, per);

endmodule

// File: rtl/nsc_seq.sv
module nsc_seq
  import nsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  s32_t  cyc,
  output step_e step,
  output logic  capture,
  output s32_t  rs_f,
  output s32_t  rst_f,
  output s32_t  rh_f,
  output s32_t  ta_f,
  output s32_t  ws_f,
  output s32_t  wst_f,
  output s32_t  wh_f,
  output logic  done
);

  step_e state;
  s32_t  tmp, lim;

  // Named events for the grow loops and the assertions
  logic rd_acc_met, rd_cyc_met, wr_dat_met, wr_cyc_met, idle_like;
  s32_t cyc_m1, max_m1;

  assign rd_acc_met = (rs_f + rst_f) >= lim;
  assign rd_cyc_met = (rs_f + rst_f + rh_f) >= lim;
  assign wr_dat_met = (ws_f + wst_f) >= lim;
  assign wr_cyc_met = (ws_f + wst_f + wh_f) >= lim;
  assign idle_like  = (state == ST_IDLE) || (state == ST_DONE);
  assign capture    = start && idle_like;
  assign cyc_m1     = floor0(cyc - 32'sd1);
  assign max_m1     = floor0(smax(tmp, cyc) - 32'sd1);
  assign step       = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      tmp   <= '0;
      lim   <= '0;
      rs_f  <= '0;
      rst_f <= '0;
      rh_f  <= '0;
      ta_f  <= '0;
      ws_f  <= '0;
      wst_f <= '0;
      wh_f  <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (capture) begin
          done  <= 1'b0;
          state <= ST_CLR;
        end
        ST_CLR:  begin rs_f  <= cyc_m1;              state <= ST_REA;  end
        ST_REA:  begin tmp   <= cyc;                 state <= ST_RP;   end
        ST_RP:   begin rst_f <= max_m1;              state <= ST_CEA;  end
        ST_CEA:  begin lim   <= cyc - 32'sd2;        state <= ST_GRS;  end
        ST_GRS:  if (rd_acc_met) state <= ST_CHZH; else rst_f <= rst_f + 32'sd1;
        ST_CHZH: begin rh_f  <= cyc_m1;              state <= ST_RC;   end
        ST_RC:   begin lim   <= cyc - 32'sd3;        state <= ST_GRH;  end
        ST_GRH:  if (rd_cyc_met) state <= ST_RHZ; else rh_f <= rh_f + 32'sd1;
        ST_RHZ:  begin tmp   <= cyc;                 state <= ST_CHZ;  end
        ST_CHZ:  begin ta_f  <= max_m1;              state <= ST_WP;   end
        ST_WP:   begin wst_f <= cyc_m1;              state <= ST_CLS;  end
        ST_CLS:  begin tmp   <= cyc;                 state <= ST_ALS;  end
        ST_ALS:  begin tmp   <= smax(tmp, cyc);      state <= ST_CS;   end
        ST_CS:   begin ws_f  <= max_m1;              state <= ST_DS;   end
        ST_DS:   begin lim   <= cyc - 32'sd2;        state <= ST_GWS;  end
        ST_GWS:  if (wr_dat_met) state <= ST_CLH; else wst_f <= wst_f + 32'sd1;
        ST_CLH:  begin tmp   <= cyc;                 state <= ST_ALH;  end
        ST_ALH:  begin tmp   <= smax(tmp, cyc);      state <= ST_CH;   end
        ST_CH:   begin tmp   <= smax(tmp, cyc);      state <= ST_DH;   end
        ST_DH:   begin wh_f  <= max_m1;              state <= ST_WC;   end
        ST_WC:   begin lim   <= cyc - 32'sd2;        state <= ST_GWH;  end
        ST_GWH:  if (wr_cyc_met) begin
          state <= ST_DONE;
          done  <= 1'b1;
        end else wh_f <= wh_f + 32'sd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the strobe grows by exactly one per clock while short
  p_grow_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRS && !rd_acc_met) |=> (rst_f == $past(rst_f) + 32'sd1));

  // R3: the access constraint still holds once the read hold is loaded
  p_access_met_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHZH) |-> rd_acc_met);

  // R4: the read-cycle constraint holds when turnaround work begins
  p_rdcycle_met_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RHZ) |-> rd_cyc_met);

  // R6: the data-setup constraint holds when the write hold work begins
  p_wdata_met_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLH) |-> wr_dat_met);

  // R7: the write-cycle constraint holds whenever results are valid
  p_wcycle_met_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_cyc_met);

  // R1: no reported field is negative
  p_nonneg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(rs_f[TW-1] | rst_f[TW-1] | rh_f[TW-1] | ta_f[TW-1] |
               ws_f[TW-1] | wst_f[TW-1] | wh_f[TW-1]));

  // R8: results hold while no new start arrives
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(rs_f) && $stable(rst_f) && $stable(rh_f) &&
                          $stable(ta_f) && $stable(ws_f) && $stable(wst_f) && $stable(wh_f)));

  // R8: an accepted start clears done on the next cycle
  p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !done);

  // R9: a start during a run does not clear done or restart the sequence
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle_like && state != ST_GWH) |=> !done && state != ST_CLR);

endmodule

// File: rtl/nand_strobe_calc.sv
module nand_strobe_calc
  import nsc_pkg::*;
#(
  parameter int IN_SETUP_PS = 3000,
  parameter int IN_HOLD_PS  = 1600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   period_ns,
  input  logic [31:0]   clr_dly_ps,
  input  logic [31:0]   re_access_ps,
  input  logic [31:0]   re_pulse_ps,
  input  logic [31:0]   ce_access_ps,
  input  logic [31:0]   ce_hiz_ps,
  input  logic [31:0]   rd_cycle_ps,
  input  logic [31:0]   re_hiz_ps,
  input  logic [31:0]   we_pulse_ps,
  input  logic [31:0]   cle_setup_ps,
  input  logic [31:0]   ale_setup_ps,
  input  logic [31:0]   ce_setup_ps,
  input  logic [31:0]   dat_setup_ps,
  input  logic [31:0]   cle_hold_ps,
  input  logic [31:0]   ale_hold_ps,
  input  logic [31:0]   ce_hold_ps,
  input  logic [31:0]   dat_hold_ps,
  input  logic [31:0]   wr_cycle_ps,
  output logic [31:0]   rd_setup,
  output logic [31:0]   rd_strobe,
  output logic [31:0]   rd_hold,
  output logic [31:0]   turnaround,
  output logic [31:0]   wr_setup,
  output logic [31:0]   wr_strobe,
  output logic [31:0]   wr_hold,
  output logic          done
);

  timing_t t_in;
  step_e   step;
  logic    capture;
  s32_t    operand, per_q, cyc;
  s32_t    rs_f, rst_f, rh_f, ta_f, ws_f, wst_f, wh_f;

  assign t_in = '{
    clr_dly:   s32_t'(clr_dly_ps),   re_access: s32_t'(re_access_ps),
    re_pulse:  s32_t'(re_pulse_ps),  ce_access: s32_t'(ce_access_ps),
    ce_hiz:    s32_t'(ce_hiz_ps),    rd_cycle:  s32_t'(rd_cycle_ps),
    re_hiz:    s32_t'(re_hiz_ps),    we_pulse:  s32_t'(we_pulse_ps),
    cle_setup: s32_t'(cle_setup_ps), ale_setup: s32_t'(ale_setup_ps),
    ce_setup:  s32_t'(ce_setup_ps),  dat_setup: s32_t'(dat_setup_ps),
    cle_hold:  s32_t'(cle_hold_ps),  ale_hold:  s32_t'(ale_hold_ps),
    ce_hold:   s32_t'(ce_hold_ps),   dat_hold:  s32_t'(dat_hold_ps),
    wr_cycle:  s32_t'(wr_cycle_ps)
  };

  nsc_opsel #(.IN_SETUP_PS(IN_SETUP_PS), .IN_HOLD_PS(IN_HOLD_PS)) u_opsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .t_in     (t_in),
    .per_in   (s32_t'(period_ns)),
    .step     (step),
    .hold_now (rh_f),
    .operand  (operand),
    .per_q    (per_q)
  );

  nsc_cycconv u_conv (
    .operand (operand),
    .per     (per_q),
    .cycles  (cyc)
  );

  nsc_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cyc     (cyc),
    .step    (step),
    .capture (capture),
    .rs_f    (rs_f),
    .rst_f   (rst_f),
    .rh_f    (rh_f),
    .ta_f    (ta_f),
    .ws_f    (ws_f),
    .wst_f   (wst_f),
    .wh_f    (wh_f),
    .done    (done)
  );

  assign rd_setup   = rs_f;
  assign rd_strobe  = rst_f;
  assign rd_hold    = rh_f;
  assign turnaround = ta_f;
  assign wr_setup   = ws_f;
  assign wr_strobe  = wst_f;
  assign wr_hold    = wh_f;

endmodule

// File: tb/sim_nand_strobe_calc.sv
module sim_nand_strobe_calc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] period_ns = 32'd1;
  logic [31:0] clr, rea, rp, cea, chz, rc, rhz, wp, cls, als, cs, ds, clh, alh, ch, dh, wc;
  logic [31:0] rd_setup, rd_strobe, rd_hold, turnaround, wr_setup, wr_strobe, wr_hold;
  logic done;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_strobe_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ns(period_ns),
    .clr_dly_ps(clr), .re_access_ps(rea), .re_pulse_ps(rp), .ce_access_ps(cea),
    .ce_hiz_ps(chz), .rd_cycle_ps(rc), .re_hiz_ps(rhz), .we_pulse_ps(wp),
    .cle_setup_ps(cls), .ale_setup_ps(als), .ce_setup_ps(cs), .dat_setup_ps(ds),
    .cle_hold_ps(clh), .ale_hold_ps(alh), .ce_hold_ps(ch), .dat_hold_ps(dh),
    .wr_cycle_ps(wc),
    .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold),
    .turnaround(turnaround), .wr_setup(wr_setup), .wr_strobe(wr_strobe),
    .wr_hold(wr_hold), .done(done)
  );

  int prof [4][17];
  int exp_f [7];

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int cyc_of(int ps, int per);
    int whole_ns;
    whole_ns = ps / 1000;
    return (whole_ns + per - 1) / per;
  endfunction

  function automatic int pos(int v);
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic int big(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Expected fields: the grow loops restated as closed-form lower bounds
  task automatic model(int p, int per);
    int rs, rst, rh, ta, ws, wst, wh;
    rs  = pos(cyc_of(prof[p][0], per) - 1);
    rst = pos(big(cyc_of(prof[p][1] + 3000, per), cyc_of(prof[p][2], per)) - 1);
    rst = big(rst, cyc_of(prof[p][3] + 3000, per) - 2 - rs);
    rh  = pos(cyc_of(1600 - prof[p][4], per) - 1);
    rh  = big(rh, cyc_of(prof[p][5], per) - 3 - rs - rst);
    ta  = pos(big(cyc_of(prof[p][6] - (rh + 1) * per * 1000, per), cyc_of(prof[p][4], per)) - 1);
    wst = pos(cyc_of(prof[p][7], per) - 1);
    ws  = pos(big(big(cyc_of(prof[p][8], per), cyc_of(prof[p][9], per)), cyc_of(prof[p][10], per)) - 1);
    wst = big(wst, cyc_of(prof[p][11], per) - 2 - ws);
    wh  = pos(big(big(cyc_of(prof[p][12], per), cyc_of(prof[p][13], per)),
                  big(cyc_of(prof[p][14], per), cyc_of(prof[p][15], per))) - 1);
    wh  = big(wh, cyc_of(prof[p][16], per) - 2 - ws - wst);
    exp_f = '{rs, rst, rh, ta, ws, wst, wh};
  endtask

  task automatic apply(int p, int per);
    period_ns = per;
    clr = prof[p][0];  rea = prof[p][1];  rp  = prof[p][2];  cea = prof[p][3];
    chz = prof[p][4];  rc  = prof[p][5];  rhz = prof[p][6];  wp  = prof[p][7];
    cls = prof[p][8];  als = prof[p][9];  cs  = prof[p][10]; ds  = prof[p][11];
    clh = prof[p][12]; alh = prof[p][13]; ch  = prof[p][14]; dh  = prof[p][15];
    wc  = prof[p][16];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL R8: done never rose, actual 0 expected 1");
    end
  endtask

  task automatic cmp_fields();
    chk("R2 rd_setup",   int'(rd_setup),   exp_f[0]);
    chk("R3 rd_strobe",  int'(rd_strobe),  exp_f[1]);
    chk("R4 rd_hold",    int'(rd_hold),    exp_f[2]);
    chk("R5 turnaround", int'(turnaround), exp_f[3]);
    chk("R6 wr_setup",   int'(wr_setup),   exp_f[4]);
    chk("R6 wr_strobe",  int'(wr_strobe),  exp_f[5]);
    chk("R7 wr_hold",    int'(wr_hold),    exp_f[6]);
    chk("R1 nonneg", int'(rd_setup[31] | rd_strobe[31] | rd_hold[31] | turnaround[31] |
                          wr_setup[31] | wr_strobe[31] | wr_hold[31]), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // slow part, negative CE-high-to-Z hold difference
    prof[0] = '{10000, 30000, 50000, 100000, 50000, 100000, 200000, 50000,
                50000, 50000, 70000, 40000, 20000, 20000, 20000, 20000, 100000};
    // fast part that forces hold and write-hold growth
    prof[1] = '{10000, 20000, 12000, 25000, 0, 60000, 100000, 10000,
                10000, 12000, 20000, 10000, 5000, 5000, 7000, 5000, 45000};
    // all zero: every field floors at zero
    prof[2] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    // long access and cycle times to force large strobe growth
    prof[3] = '{15000, 18000, 20000, 140000, 1000, 150000, 30000, 15000,
                25000, 9000, 35000, 120000, 5000, 10000, 5000, 8000, 160000};
    apply(0, 1);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset rd_strobe", int'(rd_strobe), 0);
    chk("R8 reset wr_hold", int'(wr_hold), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R7 sweep over profiles and periods
    for (int p = 0; p < 4; p++) begin
      for (int per = 1; per <= 12; per++) begin
        apply(p, per);
        model(p, per);
        pulse_start();
        chk("R8 done drop", int'(done), 0);
        wait_done();
        cmp_fields();
      end
    end

    // R8 hold after done
    repeat (6) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    cmp_fields();

    // R9 mid-run start and input change are ignored
    apply(0, 3);
    model(0, 3);
    pulse_start();
    repeat (3) @(negedge clk);
    apply(1, 7);
    pulse_start();
    wait_done();
    cmp_fields();

    // R9 inputs changed after done do not alter results; restart uses new ones
    apply(3, 2);
    repeat (4) @(negedge clk);
    cmp_fields();
    model(3, 2);
    pulse_start();
    wait_done();
    cmp_fields();

    finish_run();
  end

endmodule